// File: doc/BRIEF.md
# Retimed Pattern-Match Correlator

The block watches a stream of fixed-width symbols, at most one per clock, and reports how many of the four most recent accepted symbols line up with a four-symbol reference pattern fixed at elaboration time. The result is a count from 0 to 4 with a strobe that marks it as meaningful. Typical use is to detect a sync word in a serial data stream, where a count of 4 means an exact hit and lower counts give a soft score.

The straightforward tapped-delay-line form (one shift register, four comparators, a three-adder sum) places one comparator and three adders in a single cycle. Here the registers are moved forward through the adder tree. Every new symbol is compared against all four pattern slots at the same time. The match bits then go into a chain of partial-sum registers, so each stage holds only one comparator and one adder. The counting function stays the same. The result is registered once and appears one cycle after the symbol that completes the window.

The window moves only on cycles where the input strobe is high, so idle gaps in the stream are skipped rather than counted. A synchronous reset empties the window, and four fresh symbols are then needed before the strobe rises again.

Top module: `corr_retimed`

## Requirements
- R1: After an accepted symbol x[t], the count equals match(x[t],slot0) + match(x[t-1],slot1) + match(x[t-2],slot2) + match(x[t-3],slot3). Here x[t-k] is the k-th earlier accepted symbol, slot k is bits [k*SYM_W +: SYM_W] of the PATTERN parameter, and match is 1 on equality and 0 otherwise.
- R2: out_valid is high in the cycle after an accepted symbol only if that symbol is at least the fourth accepted since reset. It is low in every other cycle.
- R3: A cycle with in_valid low does not move the window, and in_sym is ignored. In the following cycle out_valid is low, out_count keeps its value, and the next accepted symbol is scored as if the idle cycle had not occurred.
- R4: While rst is high at a clock edge, out_valid and out_count are both 0 after that edge. Symbols accepted before reset never contribute to later counts, and four new symbols are needed before out_valid rises.
- R5: out_count never exceeds 4.
- R6: The count reaches both extremes: 4 when the window equals the pattern exactly, and 0 when no position agrees. It also reports the partial values 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when in_sym carries a symbol to accept |
| in_sym | input | SYM_W | Incoming symbol |
| out_valid | output | 1 | High when out_count scores a full window |
| out_count | output | 3 | Number of matching positions, 0 to 4 |

## Verification
Every result is due exactly one clock edge after the symbol that produces it. The bench drives each input on a falling edge and reads the outputs on the next falling edge, which lies after the single rising edge the result needs. The same one-cycle sampling applies to idle cycles, where the held count and the low strobe are read one edge after in_valid falls. After a reset, the checks expect the strobe to stay low for the first three accepted symbols and to rise one edge after the fourth.

// File: rtl/corr_pkg.sv
package corr_pkg;

    // Window length of the correlator; the sum chain is built from it.
    localparam int TAPS  = 4;
    localparam int CNT_W = $clog2(TAPS + 1);

    typedef logic [CNT_W-1:0] cnt_t;

endpackage

// File: rtl/corr_match_bank.sv
// Compares one incoming symbol against every pattern slot at once.
module corr_match_bank
    import corr_pkg::*;
#(
    parameter int                    SYM_W   = 8,
    parameter logic [TAPS*SYM_W-1:0] PATTERN = '0
) (
    input  logic [SYM_W-1:0] sym,
    output logic [TAPS-1:0]  hit
);

    for (genvar k = 0; k < TAPS; k++) begin : g_cmp
        localparam logic [SYM_W-1:0] SLOT = PATTERN[k*SYM_W +: SYM_W];
        always_comb begin
            hit[k] = (sym == SLOT);
        end
    end

endmodule

// File: rtl/corr_sum_chain.sv
// Retimed adder chain: each stage adds one fresh match bit to the
// partial sum carried from the previous accepted symbol.
module corr_sum_chain
    import corr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [TAPS-1:0] hit,
    output cnt_t            total
);

    localparam int NPART = TAPS - 1;

    typedef struct packed {
        cnt_t [NPART-1:0] part;
        cnt_t             total;
    } chain_t;

    chain_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            // Deepest stage starts a sum with the oldest slot's match.
            st_d.part[NPART-1] = cnt_t'(hit[TAPS-1]);
            for (int k = 0; k < NPART - 1; k++) begin
                st_d.part[k] = st_q.part[k+1] + cnt_t'(hit[k+1]);
            end
            st_d.total = st_q.part[0] + cnt_t'(hit[0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign total = st_q.total;

endmodule

// File: rtl/corr_fill_tracker.sv
// Counts accepted symbols after reset and raises the strobe once the
// window is full.
module corr_fill_tracker
    import corr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic vld
);

    localparam int SEEN_W = $clog2(TAPS);
    localparam logic [SEEN_W-1:0] FULL = SEEN_W'(TAPS - 1);

    typedef struct packed {
        logic [SEEN_W-1:0] seen;
        logic              vld;
    } fill_t;

    fill_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = adv && (st_q.seen == FULL);
        if (adv && (st_q.seen != FULL)) begin
            st_d.seen = st_q.seen + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld = st_q.vld;

endmodule

// File: rtl/corr_retimed.sv
module corr_retimed
    import corr_pkg::*;
#(
    parameter int                    SYM_W   = 8,
    parameter logic [TAPS*SYM_W-1:0] PATTERN = 32'h4433_2211
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_sym,
    output logic             out_valid,
    output logic [2:0]       out_count
);

    logic [TAPS-1:0] hit;
    cnt_t            total;

    corr_match_bank #(
        .SYM_W  (SYM_W),
        .PATTERN(PATTERN)
    ) u_bank (
        .sym(in_sym),
        .hit(hit)
    );

    corr_sum_chain u_chain (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_valid),
        .hit  (hit),
        .total(total)
    );

    corr_fill_tracker u_fill (
        .clk(clk),
        .rst(rst),
        .adv(in_valid),
        .vld(out_valid)
    );

    assign out_count = 3'(total);

endmodule

// File: rtl/corr_retimed_chk.sv
module corr_retimed_chk
    import corr_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [SYM_W-1:0] in_sym,
    input logic             out_valid,
    input logic [2:0]       out_count
);

    logic [3:0] seen_q    = '0;
    logic       started_q = 1'b0;

    always_ff @(posedge clk) begin
        started_q <= 1'b1;
        if (rst) begin
            seen_q <= '0;
        end else if (in_valid && seen_q < 4'(TAPS)) begin
            seen_q <= seen_q + 4'd1;
        end
    end

    // R2: the strobe needs an accepted symbol one cycle earlier
    a_r2_strobe_after_symbol: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R2: the strobe needs a full window since reset
    a_r2_window_full: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_q >= 4'(TAPS)));

    // R3: an idle cycle holds the count and lowers the strobe
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_count) && !out_valid));

    // R4: outputs cleared after a reset edge
    a_r4_reset_clears: assert property (@(posedge clk)
        (started_q && $past(rst)) |-> (!out_valid && out_count == 3'd0));

    // R5: count bounded by the window length
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        out_count <= 3'(TAPS));

    logic unused_ok;
    assign unused_ok = ^in_sym;

endmodule

bind corr_retimed corr_retimed_chk #(.SYM_W(SYM_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sym   (in_sym),
    .out_valid(out_valid),
    .out_count(out_count)
);

// File: tb/tb_corr_retimed.sv
`timescale 1ns/1ps
module tb_corr_retimed;

    localparam int          SYM_W   = 8;
    localparam logic [31:0] PATTERN = 32'h4433_2211;
    localparam int          NVEC    = 22;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [SYM_W-1:0] in_sym = '0;
    logic             out_valid;
    logic [2:0]       out_count;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    corr_retimed #(.SYM_W(SYM_W), .PATTERN(PATTERN)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
        .out_valid(out_valid), .out_count(out_count)
    );

    // {in_valid, in_sym, expected out_valid, expected count, check count}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 8'h44, 1'b0, 3'd0, 1'b0},
        {1'b1, 8'h33, 1'b0, 3'd0, 1'b0},
        {1'b1, 8'h22, 1'b0, 3'd0, 1'b0},
        {1'b1, 8'h11, 1'b1, 3'd4, 1'b1},
        {1'b0, 8'hAA, 1'b0, 3'd4, 1'b1},
        {1'b1, 8'h44, 1'b1, 3'd0, 1'b1},
        {1'b1, 8'h33, 1'b1, 3'd0, 1'b1},
        {1'b1, 8'h22, 1'b1, 3'd0, 1'b1},
        {1'b1, 8'h11, 1'b1, 3'd4, 1'b1},
        {1'b1, 8'h11, 1'b1, 3'd1, 1'b1},
        {1'b0, 8'h11, 1'b0, 3'd1, 1'b1},
        {1'b0, 8'h99, 1'b0, 3'd1, 1'b1},
        {1'b1, 8'h44, 1'b1, 3'd0, 1'b1},
        {1'b1, 8'h33, 1'b1, 3'd0, 1'b1},
        {1'b1, 8'h55, 1'b1, 3'd0, 1'b1},
        {1'b1, 8'h55, 1'b1, 3'd2, 1'b1},
        {1'b1, 8'h11, 1'b1, 3'd1, 1'b1},
        {1'b1, 8'h44, 1'b1, 3'd0, 1'b1},
        {1'b1, 8'h33, 1'b1, 3'd0, 1'b1},
        {1'b1, 8'h22, 1'b1, 3'd0, 1'b1},
        {1'b1, 8'h77, 1'b1, 3'd3, 1'b1},
        {1'b0, 8'h00, 1'b0, 3'd3, 1'b1}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [SYM_W-1:0] s);
        in_valid = v;
        in_sym   = s;
        @(negedge clk);
    endtask

    // independent behavioural model state
    logic [SYM_W-1:0] hist [4];
    int               nseen;

    function automatic int model_count();
        int c = 0;
        for (int k = 0; k < 4; k++) begin
            if (hist[k] == PATTERN[k*SYM_W +: SYM_W]) c++;
        end
        return c;
    endfunction

    initial begin
        #2_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R4: reset state
        check(out_valid == 1'b0, "R4 reset out_valid", out_valid, 0);
        check(out_count == 3'd0, "R4 reset out_count", out_count, 0);
        rst = 1'b0;

        // R1 R2 R3 R6: vector table
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][13], VEC[i][12:5]);
            check(out_valid == VEC[i][4], VEC[i][13] ? "R2 strobe" : "R3 idle strobe",
                  out_valid, VEC[i][4]);
            if (VEC[i][0]) begin
                check(out_count == VEC[i][3:1], VEC[i][13] ? "R1 R6 count" : "R3 held count",
                      out_count, VEC[i][3:1]);
            end
        end

        // R4: mid-stream reset discards history
        drive(1'b1, 8'h44);
        drive(1'b1, 8'h33);
        rst = 1'b1;
        drive(1'b0, 8'h00);
        check(out_valid == 1'b0, "R4 reset out_valid", out_valid, 0);
        check(out_count == 3'd0, "R4 reset out_count", out_count, 0);
        rst = 1'b0;
        drive(1'b1, 8'h22);
        check(out_valid == 1'b0, "R4 refill 1", out_valid, 0);
        drive(1'b1, 8'h11);
        check(out_valid == 1'b0, "R4 refill 2", out_valid, 0);
        drive(1'b1, 8'h44);
        check(out_valid == 1'b0, "R4 refill 3", out_valid, 0);
        drive(1'b1, 8'h11);
        check(out_valid == 1'b1, "R4 refill 4 strobe", out_valid, 1);
        // window 22,11,44,11: newest 11 hits slot0 only
        check(out_count == 3'd1, "R4 R1 refill count", out_count, 1);

        // R1 R2 R3 R5: model-driven pseudo-random stream
        rst = 1'b1;
        drive(1'b0, 8'h00);
        rst = 1'b0;
        nseen = 0;
        for (int k = 0; k < 4; k++) hist[k] = '0;
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            logic             v;
            logic [SYM_W-1:0] s;
            int               prev_cnt;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = (lfsr[2:0] != 3'd0);
            case (lfsr[6:4])
                3'd0, 3'd1: s = 8'h11;
                3'd2:       s = 8'h22;
                3'd3:       s = 8'h33;
                3'd4:       s = 8'h44;
                default:    s = lfsr[15:8];
            endcase
            prev_cnt = out_count;
            if (v) begin
                for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = s;
                if (nseen < 4) nseen++;
            end
            drive(v, s);
            if (v) begin
                check(out_valid == (nseen >= 4), "R2 model strobe", out_valid, nseen >= 4);
                if (nseen >= 4)
                    check(out_count == 3'(model_count()), "R1 model count",
                          out_count, model_count());
            end else begin
                check(out_valid == 1'b0, "R3 model idle strobe", out_valid, 0);
                check(out_count == 3'(prev_cnt), "R3 model held count", out_count, prev_cnt);
            end
            check(out_count <= 3'd4, "R5 bound", out_count, 4);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule